// File: doc/BRIEF.md
# Vector Register Group Legality Checker

This block decides whether a vector instruction of the widening, narrowing or sign/zero extension class names register groups that may legally be used together. The decoder upstream supplies the destination and source register indices and the group sizes it has already derived. The checker tests three things. Each group must start on a multiple of its size. Each group must end inside the register file. A wide destination must not share registers with a narrow source.

A check is launched by pulsing `chk_en` with the operands on the inputs. One clock later `res_vld` is high and `illegal` gives the verdict. When the instruction is rejected, `fault_pc` holds the address of the offending instruction, which is the current PC minus the 4-byte instruction length. When the instruction is accepted, `fault_pc` is zero. While `chk_en` is low, the last verdict and address stay unchanged.

Top module: `vgrp_legal_chk`

## Requirements
- R1: While `rst_n` is low and after reset, `res_vld`, `illegal` and `fault_pc` are all zero until the first check.
- R2: A check with `chk_en` high during clock edge n shows its verdict after edge n+1, with `res_vld` high. When `chk_en` is low, `res_vld` drops and `illegal` and `fault_pc` keep their values.
- R3: Widening class (`op_class`=0): the instruction is illegal unless `vd_idx` is a multiple of `wide_size` and `vd_idx + wide_size <= 32`. A group ending exactly at register 32 is legal.
- R4: Widening class: the instruction is illegal if [vd_idx, vd_idx+wide_size) overlaps [vs2_idx, vs2_idx+norm_size). It is also illegal if that range overlaps [vs1_idx, vs1_idx+norm_size), but only when `vs1_present` is 1. With `vs1_present` 0, `vs1_idx` has no effect.
- R5: Two ranges [a,a+la) and [b,b+lb) overlap exactly when a < b+lb and b < a+la. Ranges that only touch at an end are legal.
- R6: Extension class (`op_class`=2): the instruction is illegal unless `vs2_idx` is a multiple of `ext_src_size` and `vs2_idx + ext_src_size <= 32`. It is also illegal if [vs2_idx, vs2_idx+ext_src_size) overlaps [vd_idx, vd_idx+norm_size). The alignment of `vd_idx` is not checked in this class.
- R7: Narrowing class (`op_class`=1): `vs2_idx` must be aligned to `wide_size` and fit within 32 registers, and `vd_idx` must be aligned to `norm_size` and fit within 32 registers. No overlap test is applied.
- R8: Every group size that the class uses must be 1, 2, 4 or 8, or the instruction is illegal. Sizes the class does not use are ignored. `op_class`=3 is always illegal.
- R9: On an illegal verdict, `fault_pc` equals `cur_pc` - 4 (modulo 2^32) as sampled with the check. On a legal verdict it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Launch a check this cycle |
| op_class | input | 2 | 0 widen, 1 narrow, 2 extend, 3 reserved |
| vd_idx | input | 5 | Destination register index |
| vs2_idx | input | 5 | First source register index |
| vs1_idx | input | 5 | Second source register index |
| vs1_present | input | 1 | Second source is a vector register |
| norm_size | input | 4 | Normal group size in registers |
| wide_size | input | 4 | Wide group size in registers |
| ext_src_size | input | 4 | Source group size for extension |
| cur_pc | input | 32 | PC following the instruction being checked |
| res_vld | output | 1 | Verdict updated this cycle |
| illegal | output | 1 | Instruction rejected |
| fault_pc | output | 32 | Address of rejected instruction, else zero |

## Verification
The stimulus places groups at aligned and misaligned starts and at the top of the register file, so that alignment faults can be told apart from bound faults. Overlap cases put the source group inside the destination group, one register below it, and touching it from either side, which separates the half-open test from a closed one. Each class is also given operands that another class would reject, such as an overlap under narrowing or an unaligned destination under extension, to show that each class applies only its own rules. Illegal group sizes, the reserved class and unused size inputs show that size screening depends on the class. A zero PC shows that the fault address wraps.

// File: rtl/vgc_pkg.sv
package vgc_pkg;
  typedef enum logic [1:0] {
    VG_WIDEN  = 2'd0,
    VG_NARROW = 2'd1,
    VG_EXTEND = 2'd2,
    VG_RSVD   = 2'd3
  } vg_class_e;
endpackage

// File: rtl/vgc_size_ok.sv
module vgc_size_ok #(
  parameter int SIZE_W    = 4,
  parameter int MAX_GROUP = 8
) (
  input  logic [SIZE_W-1:0] size,
  output logic              ok
);
  localparam int CMP_W = SIZE_W + 1;
  logic [CMP_W-1:0] size_x;

  always_comb begin
    size_x = CMP_W'(size);
    // power of two, non-zero, not above the largest group
    ok = (size_x != '0) && ((size_x & (size_x - CMP_W'(1))) == '0)
         && (size_x <= CMP_W'(MAX_GROUP));
  end
endmodule

// File: rtl/vgc_group_fit.sv
module vgc_group_fit #(
  parameter int IDX_W     = 5,
  parameter int SIZE_W    = 4,
  parameter int REG_COUNT = 32,
  parameter int MAX_GROUP = 8
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [SIZE_W-1:0] size,
  output logic              fits
);
  localparam int SUM_W = ((IDX_W > SIZE_W) ? IDX_W : SIZE_W) + 1;

  logic             size_good;
  logic [SUM_W-1:0] idx_x;
  logic [SUM_W-1:0] size_x;
  logic [SUM_W-1:0] end_x;
  logic             aligned;
  logic             in_bound;

  vgc_size_ok #(.SIZE_W(SIZE_W), .MAX_GROUP(MAX_GROUP)) u_size (
    .size (size),
    .ok   (size_good)
  );

  always_comb begin
    idx_x    = SUM_W'(idx);
    size_x   = SUM_W'(size);
    end_x    = idx_x + size_x;
    aligned  = (idx_x & (size_x - SUM_W'(1))) == '0;
    in_bound = end_x <= SUM_W'(REG_COUNT);
    fits     = size_good && aligned && in_bound;
  end
endmodule

// File: rtl/vgc_overlap.sv
module vgc_overlap #(
  parameter int IDX_W  = 5,
  parameter int SIZE_W = 4
) (
  input  logic [IDX_W-1:0]  a_base,
  input  logic [SIZE_W-1:0] a_len,
  input  logic [IDX_W-1:0]  b_base,
  input  logic [SIZE_W-1:0] b_len,
  output logic              hit
);
  localparam int SUM_W = ((IDX_W > SIZE_W) ? IDX_W : SIZE_W) + 1;

  logic [SUM_W-1:0] a_lo, a_hi, b_lo, b_hi;

  always_comb begin
    a_lo = SUM_W'(a_base);
    b_lo = SUM_W'(b_base);
    a_hi = a_lo + SUM_W'(a_len);
    b_hi = b_lo + SUM_W'(b_len);
    hit  = (a_lo < b_hi) && (b_lo < a_hi);
  end
endmodule

// File: rtl/vgrp_legal_chk.sv
module vgrp_legal_chk
  import vgc_pkg::*;
#(
  parameter int REG_COUNT  = 32,
  parameter int SIZE_W     = 4,
  parameter int MAX_GROUP  = 8,
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4,
  localparam int IDX_W     = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic [1:0]        op_class,
  input  logic [IDX_W-1:0]  vd_idx,
  input  logic [IDX_W-1:0]  vs2_idx,
  input  logic [IDX_W-1:0]  vs1_idx,
  input  logic              vs1_present,
  input  logic [SIZE_W-1:0] norm_size,
  input  logic [SIZE_W-1:0] wide_size,
  input  logic [SIZE_W-1:0] ext_src_size,
  input  logic [PC_W-1:0]   cur_pc,
  output logic              res_vld,
  output logic              illegal,
  output logic [PC_W-1:0]   fault_pc
);
  vg_class_e cls;
  logic norm_ok;
  logic vd_wide_fit, vd_norm_fit, vs2_wide_fit, vs2_src_fit;
  logic ovl_wd_vs2, ovl_wd_vs1, ovl_ext;
  logic bad;

  logic            vld_d, vld_q;
  logic            ill_d, ill_q;
  logic [PC_W-1:0] pc_d,  pc_q;

  assign cls = vg_class_e'(op_class);

  vgc_size_ok #(.SIZE_W(SIZE_W), .MAX_GROUP(MAX_GROUP)) u_norm_ok (
    .size (norm_size),
    .ok   (norm_ok)
  );

  vgc_group_fit #(.IDX_W(IDX_W), .SIZE_W(SIZE_W), .REG_COUNT(REG_COUNT),
                  .MAX_GROUP(MAX_GROUP)) u_fit_vd_wide (
    .idx (vd_idx), .size (wide_size), .fits (vd_wide_fit)
  );
  vgc_group_fit #(.IDX_W(IDX_W), .SIZE_W(SIZE_W), .REG_COUNT(REG_COUNT),
                  .MAX_GROUP(MAX_GROUP)) u_fit_vd_norm (
    .idx (vd_idx), .size (norm_size), .fits (vd_norm_fit)
  );
  vgc_group_fit #(.IDX_W(IDX_W), .SIZE_W(SIZE_W), .REG_COUNT(REG_COUNT),
                  .MAX_GROUP(MAX_GROUP)) u_fit_vs2_wide (
    .idx (vs2_idx), .size (wide_size), .fits (vs2_wide_fit)
  );
  vgc_group_fit #(.IDX_W(IDX_W), .SIZE_W(SIZE_W), .REG_COUNT(REG_COUNT),
                  .MAX_GROUP(MAX_GROUP)) u_fit_vs2_src (
    .idx (vs2_idx), .size (ext_src_size), .fits (vs2_src_fit)
  );

  vgc_overlap #(.IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_ovl_wd_vs2 (
    .a_base (vd_idx), .a_len (wide_size),
    .b_base (vs2_idx), .b_len (norm_size), .hit (ovl_wd_vs2)
  );
  vgc_overlap #(.IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_ovl_wd_vs1 (
    .a_base (vd_idx), .a_len (wide_size),
    .b_base (vs1_idx), .b_len (norm_size), .hit (ovl_wd_vs1)
  );
  vgc_overlap #(.IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_ovl_ext (
    .a_base (vs2_idx), .a_len (ext_src_size),
    .b_base (vd_idx), .b_len (norm_size), .hit (ovl_ext)
  );

  // class-specific verdict
  always_comb begin
    unique case (cls)
      VG_WIDEN:  bad = !vd_wide_fit || !norm_ok || ovl_wd_vs2
                       || (vs1_present && ovl_wd_vs1);
      VG_NARROW: bad = !vs2_wide_fit || !vd_norm_fit;
      VG_EXTEND: bad = !vs2_src_fit || !norm_ok || ovl_ext;
      default:   bad = 1'b1;
    endcase
  end

  // next state
  always_comb begin
    vld_d = chk_en;
    ill_d = ill_q;
    pc_d  = pc_q;
    if (chk_en) begin
      ill_d = bad;
      pc_d  = bad ? (cur_pc - PC_W'(INSN_BYTES)) : '0;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ill_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      vld_q <= vld_d;
      ill_q <= ill_d;
      pc_q  <= pc_d;
    end
  end

  assign res_vld  = vld_q;
  assign illegal  = ill_q;
  assign fault_pc = pc_q;

  AST_VLD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |=> res_vld); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> ($stable(illegal) && $stable(fault_pc))); // R2
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && illegal) |-> (fault_pc == $past(cur_pc) - PC_W'(INSN_BYTES))); // R9
  AST_LEGAL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !illegal) |-> (fault_pc == '0)); // R9
  AST_RSVD_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && op_class == 2'd3) |=> illegal); // R8
  AST_WIDEN_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && op_class == 2'd0 && ((IDX_W'(vd_idx) & IDX_W'(wide_size - 1'b1)) != '0))
    |=> illegal); // R3
  AST_NARROW_VD_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && op_class == 2'd1 && ((IDX_W'(vd_idx) & IDX_W'(norm_size - 1'b1)) != '0))
    |=> illegal); // R7
endmodule

// File: tb/tb_vgrp_legal_chk.sv
`timescale 1ns/1ps
module tb_vgrp_legal_chk;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        chk_en;
  logic [1:0]  op_class;
  logic [4:0]  vd_idx, vs2_idx, vs1_idx;
  logic        vs1_present;
  logic [3:0]  norm_size, wide_size, ext_src_size;
  logic [31:0] cur_pc;
  logic        res_vld, illegal;
  logic [31:0] fault_pc;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  bit          q_ill[$];
  logic [31:0] q_pc[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  vgrp_legal_chk dut (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .op_class(op_class),
    .vd_idx(vd_idx), .vs2_idx(vs2_idx), .vs1_idx(vs1_idx),
    .vs1_present(vs1_present), .norm_size(norm_size), .wide_size(wide_size),
    .ext_src_size(ext_src_size), .cur_pc(cur_pc),
    .res_vld(res_vld), .illegal(illegal), .fault_pc(fault_pc)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // driver: apply one check, push expected verdict
  task automatic drive(input logic [1:0] op, input int vd, input int vs2,
                       input int vs1, input bit has1, input int ns,
                       input int ws, input int ss, input logic [31:0] pc,
                       input bit exp_ill, input string tag);
    @(negedge clk);
    chk_en = 1'b1; op_class = op;
    vd_idx = 5'(vd); vs2_idx = 5'(vs2); vs1_idx = 5'(vs1);
    vs1_present = has1;
    norm_size = 4'(ns); wide_size = 4'(ws); ext_src_size = 4'(ss);
    cur_pc = pc;
    q_ill.push_back(exp_ill);
    q_pc.push_back(exp_ill ? pc - 32'd4 : 32'd0);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_en = 1'b0;
    end
  endtask

  // monitor: compare each result against the scoreboard
  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      if (q_ill.size() == 0) begin
        check(1'b0, "R2", "result with empty scoreboard");
      end else begin
        bit          e_ill;
        logic [31:0] e_pc;
        string       t;
        e_ill = q_ill.pop_front();
        e_pc  = q_pc.pop_front();
        t     = q_tag.pop_front();
        check(illegal == e_ill, t,
              $sformatf("illegal act=%0b exp=%0b", illegal, e_ill));
        check(fault_pc == e_pc, t,
              $sformatf("fault_pc act=%h exp=%h", fault_pc, e_pc));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; chk_en = 1'b0; op_class = 2'd0;
    vd_idx = '0; vs2_idx = '0; vs1_idx = '0; vs1_present = 1'b0;
    norm_size = 4'd1; wide_size = 4'd2; ext_src_size = 4'd1; cur_pc = '0;
    repeat (3) @(negedge clk);
    check(res_vld == 1'b0 && illegal == 1'b0 && fault_pc == 32'd0, "R1",
          $sformatf("in reset act=%0b/%0b/%h exp=0/0/0", res_vld, illegal, fault_pc));
    rst_n = 1'b1;
    @(negedge clk);
    check(res_vld == 1'b0 && illegal == 1'b0 && fault_pc == 32'd0, "R1",
          $sformatf("after reset act=%0b/%0b/%h exp=0/0/0", res_vld, illegal, fault_pc));

    // widening: op 0
    drive(2'd0, 4, 0, 2, 1, 2, 4, 1, 32'h1000, 0, "R5 touching sources");
    drive(2'd0, 2, 8, 12, 1, 2, 4, 1, 32'h1004, 1, "R3 misaligned vd");
    drive(2'd0, 28, 0, 2, 1, 2, 4, 1, 32'h1008, 0, "R3 ends at 32");
    drive(2'd0, 30, 0, 1, 1, 1, 2, 1, 32'h100C, 0, "R3 top pair");
    drive(2'd0, 8, 10, 0, 1, 2, 4, 1, 32'h1010, 1, "R4 vs2 inside");
    drive(2'd0, 8, 0, 11, 1, 2, 4, 1, 32'h1014, 1, "R4 vs1 inside");
    drive(2'd0, 8, 0, 11, 0, 2, 4, 1, 32'h1018, 0, "R4 vs1 absent");
    drive(2'd0, 8, 7, 0, 1, 2, 4, 1, 32'h101C, 1, "R5 straddle below");
    drive(2'd0, 8, 12, 0, 1, 2, 4, 1, 32'h1020, 0, "R5 touch above");
    // extension: op 2
    drive(2'd2, 0, 5, 0, 0, 4, 1, 2, 32'h2000, 1, "R6 misaligned src");
    drive(2'd2, 0, 4, 0, 0, 4, 1, 1, 32'h2004, 0, "R6 touch");
    drive(2'd2, 0, 2, 0, 0, 4, 1, 2, 32'h2008, 1, "R6 overlap");
    drive(2'd2, 8, 6, 0, 0, 8, 1, 2, 32'h200C, 0, "R6 below dest");
    drive(2'd2, 3, 8, 0, 0, 4, 1, 1, 32'h2010, 0, "R6 vd unchecked");
    // narrowing: op 1
    drive(2'd1, 2, 8, 0, 0, 2, 4, 1, 32'h3000, 0, "R7 legal");
    drive(2'd1, 2, 6, 0, 0, 2, 4, 1, 32'h3004, 1, "R7 wide src misaligned");
    drive(2'd1, 3, 8, 0, 0, 2, 4, 1, 32'h3008, 1, "R7 vd misaligned");
    drive(2'd1, 8, 8, 0, 0, 2, 4, 1, 32'h300C, 0, "R7 overlap ignored");
    drive(2'd1, 24, 16, 0, 1, 8, 8, 1, 32'h3010, 0, "R7 size 8");
    // sizes and class
    drive(2'd0, 8, 0, 2, 1, 3, 4, 1, 32'h4000, 1, "R8 norm size 3");
    drive(2'd3, 0, 8, 16, 0, 1, 2, 1, 32'h4004, 1, "R8 reserved class");
    drive(2'd2, 0, 8, 0, 0, 4, 1, 0, 32'h4008, 1, "R8 src size 0");
    drive(2'd1, 0, 8, 0, 0, 1, 6, 1, 32'h400C, 1, "R8 wide size 6");
    drive(2'd2, 0, 8, 0, 0, 4, 5, 1, 32'h4010, 0, "R8 unused size");
    drive(2'd0, 0, 16, 8, 1, 8, 0, 1, 32'h4014, 1, "R8 wide size 0");
    drive(2'd3, 0, 8, 0, 0, 1, 2, 1, 32'h0000_0000, 1, "R9 pc wrap");
    idle(1);

    // R2: idle cycles keep the last verdict
    drive(2'd1, 3, 8, 0, 0, 2, 4, 1, 32'h5000, 1, "R2 before hold");
    @(negedge clk);
    chk_en = 1'b0; op_class = 2'd0; vd_idx = 5'd0; vs2_idx = 5'd8;
    norm_size = 4'd1; wide_size = 4'd2; cur_pc = 32'h9999;
    @(negedge clk);
    @(negedge clk);
    check(res_vld == 1'b0, "R2", $sformatf("res_vld act=%0b exp=0", res_vld));
    check(illegal == 1'b1 && fault_pc == 32'h4FFC, "R2",
          $sformatf("hold act=%0b/%h exp=1/00004ffc", illegal, fault_pc));
    idle(2);
    check(q_ill.size() == 0, "R2",
          $sformatf("pending act=%0d exp=0", q_ill.size()));

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule